// File: doc/BRIEF.md
# Pin Interrupt Detector

This block watches a bank of general-purpose input pins and turns changes or levels on them into interrupt requests. Each pin has its own enable bit, a three-bit trigger selection split across three one-bit-per-pin planes, and a sticky status bit. The pins are first brought into the clock domain by a two-stage synchronizer. A detector then compares each synchronized value with the value from the previous cycle, or tests its level, according to that pin's trigger selection. Any detected event latches the pin's status bit.

Software programs the planes through a small word-addressed register port and reads back the status word to find which pins need service. It clears each serviced bit by writing a one to it. A single interrupt line is the OR, over all pins, of status AND enable. A disabled pin still records events in its status bit, but it does not raise the line.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset, every register (enable, all three trigger planes, status) reads zero and `irq_o` is low.
- R2: The enable plane is at byte offset 0x00, trigger plane A at 0x04, plane B at 0x08, plane C at 0x0C and status at 0x10, one bit per pin with pin n at bit n. The first four planes read back what was written. Any other offset reads zero, and a write to it changes nothing.
- R3: With the planes (A,B,C) = (0,0,0), a pin's status sets on a high-to-low transition of that pin.
- R4: With (A,B,C) = (1,0,0), status sets on a low-to-high transition.
- R5: With B=0 and C=1, status sets on either transition, whatever A holds.
- R6: With B=1, the pin is level sensed and C is ignored. A=1 sets status while the pin is high, and A=0 sets it while the pin is low.
- R7: A pin change made between two clock edges sets its status bit, and with enable raises `irq_o`, at the third rising edge that follows. The bit does not set at the second.
- R8: Status bits are sticky. Writing one to a status bit clears it, and writing zero leaves it unchanged.
- R9: If an event for a pin occurs in the same cycle as a clear of that pin's bit, the bit stays set. A level-sensed pin whose level is still active therefore still reads set after a clear.
- R10: `irq_o` is high exactly when some pin has both its status bit and its enable bit set. A disabled pin still latches status.
- R11: Read data appears on `bus_rdata` at the clock edge that samples the read request and holds until the next read.

Ports

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NPINS | Asynchronous pin inputs |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | NPINS | Write data, one bit per pin |
| bus_rdata | output | NPINS | Registered read data |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Random trigger configurations are mixed per pin across all eight plane codes. The pins then follow random patterns that are held long enough to settle. This tells apart the edge polarities, both-edge detection, and the two levels within a single status word. Partial write-one-clear masks separate the sticky bits from the cleared ones. They also show that level pins whose level is still active set again at once. Directed cases pin down the exact three-edge latency on the interrupt line, the set-wins-over-clear rule, the unused-offset behaviour, and a disabled pin that latches status without raising the line.

// File: rtl/gpirq_pkg.sv
package gpirq_pkg;

  localparam int ADDR_W = 5;

  typedef enum logic [2:0] {
    SEL_EN   = 3'd0,
    SEL_TA   = 3'd1,
    SEL_TB   = 3'd2,
    SEL_TC   = 3'd3,
    SEL_STAT = 3'd4,
    SEL_NONE = 3'd7
  } reg_sel_e;

  localparam logic [ADDR_W-1:0] OFF_EN   = 5'h00;
  localparam logic [ADDR_W-1:0] OFF_TA   = 5'h04;
  localparam logic [ADDR_W-1:0] OFF_TB   = 5'h08;
  localparam logic [ADDR_W-1:0] OFF_TC   = 5'h0C;
  localparam logic [ADDR_W-1:0] OFF_STAT = 5'h10;

  function automatic reg_sel_e decode_off(input logic [ADDR_W-1:0] a);
    reg_sel_e s;
    case (a)
      OFF_EN:   s = SEL_EN;
      OFF_TA:   s = SEL_TA;
      OFF_TB:   s = SEL_TB;
      OFF_TC:   s = SEL_TC;
      OFF_STAT: s = SEL_STAT;
      default:  s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/gpirq_sync.sv
module gpirq_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stg_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] stg_d;
      if (s == 0) begin : g_first
        assign stg_d = async_i;
      end else begin : g_next
        assign stg_d = stg_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= '0;
        else        stg_q[s] <= stg_d;
      end
    end
  endgenerate

  assign sync_o = stg_q[STAGES-1];

endmodule

// File: rtl/gpirq_detect.sv
module gpirq_detect #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] sync_i,
  input  logic [WIDTH-1:0] ta_i,
  input  logic [WIDTH-1:0] tb_i,
  input  logic [WIDTH-1:0] tc_i,
  output logic [WIDTH-1:0] evt_o
);

  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] prev_d;

  assign prev_d = sync_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  generate
    for (genvar p = 0; p < WIDTH; p++) begin : g_pin
      logic rise, fall, lvl_hit, edge_hit;
      always_comb begin
        rise     = sync_i[p] & ~prev_q[p];
        fall     = ~sync_i[p] & prev_q[p];
        lvl_hit  = (sync_i[p] == ta_i[p]);
        if (tc_i[p])      edge_hit = rise | fall;
        else if (ta_i[p]) edge_hit = rise;
        else              edge_hit = fall;
        evt_o[p] = tb_i[p] ? lvl_hit : edge_hit;
      end
    end
  endgenerate

  // R6: a level-high event needs the synchronized pin high
  a_r6_level_high_needs_high: assert property (@(posedge clk) disable iff (!rst_n)
    ((tb_i & ta_i & evt_o & ~sync_i) == '0));

  // R3: a falling-edge event never occurs with the pin high
  a_r3_fall_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
    ((~tb_i & ~tc_i & ~ta_i & evt_o & sync_i) == '0));

  // R4: a rising-edge event needs the previous sample low
  a_r4_rise_needs_prev_low: assert property (@(posedge clk) disable iff (!rst_n)
    ((~tb_i & ~tc_i & ta_i & evt_o & prev_q) == '0));

endmodule

// File: rtl/gpirq_regs.sv
module gpirq_regs
  import gpirq_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  input  logic [WIDTH-1:0]  evt_i,
  output logic [WIDTH-1:0]  en_o,
  output logic [WIDTH-1:0]  ta_o,
  output logic [WIDTH-1:0]  tb_o,
  output logic [WIDTH-1:0]  tc_o,
  output logic [WIDTH-1:0]  stat_o,
  output logic [WIDTH-1:0]  rdata_o
);

  reg_sel_e         sel;
  logic             wr_req, rd_req;
  logic             en_ce, ta_ce, tb_ce, tc_ce;
  logic [WIDTH-1:0] clr_mask;
  logic [WIDTH-1:0] en_q, ta_q, tb_q, tc_q, st_q, rd_q;
  logic [WIDTH-1:0] st_d, rd_d;

  always_comb begin
    sel      = decode_off(bus_addr);
    wr_req   = bus_sel & bus_wr;
    rd_req   = bus_sel & ~bus_wr;
    en_ce    = wr_req & (sel == SEL_EN);
    ta_ce    = wr_req & (sel == SEL_TA);
    tb_ce    = wr_req & (sel == SEL_TB);
    tc_ce    = wr_req & (sel == SEL_TC);
    clr_mask = (wr_req & (sel == SEL_STAT)) ? bus_wdata : '0;
  end

  // next-state: new events win over a simultaneous clear
  always_comb begin
    st_d = (st_q & ~clr_mask) | evt_i;
    case (sel)
      SEL_EN:   rd_d = en_q;
      SEL_TA:   rd_d = ta_q;
      SEL_TB:   rd_d = tb_q;
      SEL_TC:   rd_d = tc_q;
      SEL_STAT: rd_d = st_q;
      default:  rd_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
      ta_q <= '0;
      tb_q <= '0;
      tc_q <= '0;
      st_q <= '0;
      rd_q <= '0;
    end else begin
      if (en_ce)  en_q <= bus_wdata;
      if (ta_ce)  ta_q <= bus_wdata;
      if (tb_ce)  tb_q <= bus_wdata;
      if (tc_ce)  tc_q <= bus_wdata;
      if (rd_req) rd_q <= rd_d;
      st_q <= st_d;
    end
  end

  assign en_o    = en_q;
  assign ta_o    = ta_q;
  assign tb_o    = tb_q;
  assign tc_o    = tc_q;
  assign stat_o  = st_q;
  assign rdata_o = rd_q;

  // R8: a set bit stays set unless a one was written to it
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ((($past(st_q) & ~$past(clr_mask)) & ~st_q) == '0));

  // R8: a cleared bit with no event in that cycle reads zero
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q & $past(clr_mask) & ~$past(evt_i)) == '0));

  // R9: an event always leaves the bit set, even against a clear
  a_r9_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ((~st_q & $past(evt_i)) == '0));

  // R11: read data holds when no read was requested
  a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_req) |-> $stable(rd_q));

endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpirq_pkg::*;
#(
  parameter int NPINS       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  pin_i,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  output logic              irq_o
);

  logic [NPINS-1:0] pin_sync, evt, en, ta, tb, tc, stat;

  gpirq_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (pin_i),
    .sync_o  (pin_sync)
  );

  gpirq_detect #(.WIDTH(NPINS)) u_det (
    .clk    (clk),
    .rst_n  (rst_n),
    .sync_i (pin_sync),
    .ta_i   (ta),
    .tb_i   (tb),
    .tc_i   (tc),
    .evt_o  (evt)
  );

  gpirq_regs #(.WIDTH(NPINS)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .evt_i     (evt),
    .en_o      (en),
    .ta_o      (ta),
    .tb_o      (tb),
    .tc_o      (tc),
    .stat_o    (stat),
    .rdata_o   (bus_rdata)
  );

  assign irq_o = |(stat & en);

  // R10: with every pin disabled the line stays low
  a_r10_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> !irq_o);

  // R10: the line is low when no status bit is set
  a_r10_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(stat) == 0) |-> !irq_o);

endmodule

// File: tb/sim_gpio_irq_unit.sv
module sim_gpio_irq_unit;

  localparam int N = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] pin_i = '0;
  logic         bus_sel = 1'b0;
  logic         bus_wr = 1'b0;
  logic [4:0]   bus_addr = '0;
  logic [N-1:0] bus_wdata = '0;
  logic [N-1:0] bus_rdata;
  logic         irq_o;

  int checks = 0;
  int errors = 0;
  logic finished = 1'b0;

  always #5 clk = ~clk;

  gpio_irq_unit #(.NPINS(N)) u0 (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  function automatic logic trig(input logic old_v, input logic new_v,
                                input logic a, input logic b, input logic c);
    if (b)      return new_v == a;
    else if (c) return old_v != new_v;
    else if (a) return !old_v && new_v;
    else        return old_v && !new_v;
  endfunction

  function automatic logic [N-1:0] events(input logic [N-1:0] o, input logic [N-1:0] n,
      input logic [N-1:0] a, input logic [N-1:0] b, input logic [N-1:0] c);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = trig(o[i], n[i], a[i], b[i], c[i]);
    return r;
  endfunction

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bwrite(input logic [4:0] a, input logic [N-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bread(input logic [4:0] a, output logic [N-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    finished = 1'b1;
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual running expected done");
      finish_run();
    end
  end

  initial begin
    logic [N-1:0] rd, en, ta, tb, tc, expst, cur, nxt, msk;
    void'($urandom(32'h00C0FFEE));
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1: reset values
    bread(5'h00, rd); check("R1 enable", rd, '0);
    bread(5'h04, rd); check("R1 planeA", rd, '0);
    bread(5'h08, rd); check("R1 planeB", rd, '0);
    bread(5'h0C, rd); check("R1 planeC", rd, '0);
    bread(5'h10, rd); check("R1 status", rd, '0);
    check("R1 irq", {31'b0, irq_o}, '0);

    // R2: map and readback, unused offset
    bwrite(5'h04, 32'hA5A5_0F0F); bread(5'h04, rd); check("R2 planeA", rd, 32'hA5A5_0F0F);
    bwrite(5'h14, 32'hFFFF_FFFF); bread(5'h14, rd); check("R2 unused read", rd, '0);
    bread(5'h00, rd); check("R2 unused write no effect", rd, '0);
    bwrite(5'h04, '0);

    // R7: latency on pin 0 rising with enable
    bwrite(5'h04, 32'h1);
    bwrite(5'h00, 32'h1);
    pin_i[0] = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    check("R7 not yet at second edge", {31'b0, irq_o}, '0);
    @(posedge clk); #1;
    check("R7 set at third edge", {31'b0, irq_o}, 32'h1);
    // R8: writing zero keeps status, one clears
    bwrite(5'h10, 32'hFFFF_FFFE); bread(5'h10, rd); check("R8 zero write keeps", rd, 32'h1);
    bwrite(5'h10, 32'h1); bread(5'h10, rd); check("R8 one write clears", rd, '0);

    // R9: level-high pin still active keeps status through clear
    bwrite(5'h08, 32'h1);
    idle(4);
    bwrite(5'h10, 32'h1); bread(5'h10, rd); check("R9 level re-sets", rd, 32'h1);

    // R10: disabled pin latches but no irq
    bwrite(5'h00, '0); idle(1);
    check("R10 disabled no irq", {31'b0, irq_o}, '0);
    bread(5'h10, rd); check("R10 disabled still latches", rd, 32'h1);
    pin_i[0] = 1'b0;
    bwrite(5'h08, '0); bwrite(5'h04, '0);
    idle(4);
    bwrite(5'h10, '1);

    // R3 R4 R5 R6: random configurations and pin patterns
    cur = pin_i;
    for (int cfg = 0; cfg < 24; cfg++) begin
      en = $urandom; ta = $urandom; tb = $urandom; tc = $urandom;
      bwrite(5'h00, en); bwrite(5'h04, ta); bwrite(5'h08, tb); bwrite(5'h0C, tc);
      idle(4);
      bwrite(5'h10, '1);
      expst = tb & ~(ta ^ cur);
      for (int st = 0; st < 12; st++) begin
        nxt = (st % 3 == 0) ? ~cur : $urandom;
        pin_i = nxt;
        idle(4);
        expst = expst | events(cur, nxt, ta, tb, tc);
        cur = nxt;
        bread(5'h10, rd);
        check("R3 R4 R5 R6 status after pattern", rd, expst);
        check("R10 combined irq", {31'b0, irq_o}, {31'b0, |(expst & en)});
        if (st % 4 == 3) begin
          msk = $urandom;
          bwrite(5'h10, msk);
          expst = (expst & ~msk) | (tb & ~(ta ^ cur));
          bread(5'h10, rd);
          check("R8 R9 partial clear", rd, expst);
        end
      end
    end

    // R11: rdata holds without a read
    bread(5'h04, rd);
    idle(3);
    check("R11 rdata held", bus_rdata, rd);

    finish_run();
  end

endmodule